// File: doc/BRIEF.md
# Loss-of-clock bus cycle rescue

This block keeps an 8-bit host register interface from hanging when the line-rate clocks that time it disappear. The interface is normally clocked by either a transmit input clock or a receive line clock, each running at 34.368 MHz or 44.736 MHz. If both stop, a host read or write already in progress would never see its ready strobe. The block samples both line clocks from an independent free-running monitor clock and declares loss only when neither of them is toggling.

While loss is declared and the rescue is enabled, any host cycle that is in progress gets one forced ready pulse, so that the cycle ends. The enable is bit 7 of an I/O control register at address 0x01. That register resets to 0xA0, so the rescue is active out of reset. The normal ready from the register core always passes through unchanged.

Top module: `loc_rescue`

## Requirements
- R1: After reset the I/O control register `io_ctrl_o` reads 0xA0. Its bit 7 (rescue enable) is 1.
- R2: A cycle with `cs_i`=1 and `we_i`=1 at address 0x01 loads `wdata_i` into the register on that clock. A write to any other address leaves the register unchanged.
- R3: While bit 7 of the register is 0, no ready is forced, even with both line clocks stopped.
- R4: No ready is forced while at least one of the two line clocks is still toggling.
- R5: Each line clock passes through a two-flop synchroniser. An input counts as dead once 16 monitor cycles pass with no change in its synchronised value. A forced ready never appears within the first 17 monitor cycles after both inputs stop.
- R6: The forced ready is a pulse one clock wide and is issued once per host cycle (`cs_i` held high). It re-arms only after `cs_i` has been low for at least one clock.
- R7: Loss clears as soon as either input toggles again. A host cycle that starts afterwards gets no forced ready.
- R8: `rdy_o` is 1 whenever `core_rdy_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running monitor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_clk_i | input | 1 | Transmit input line clock, sampled as data |
| rx_clk_i | input | 1 | Receive line clock, sampled as data |
| cs_i | input | 1 | Host chip select, high for the whole cycle |
| we_i | input | 1 | Host write strobe |
| addr_i | input | 8 | Host register address |
| wdata_i | input | 8 | Host write data |
| core_rdy_i | input | 1 | Normal ready from the register core |
| rdy_o | output | 1 | Ready to host: core ready or forced pulse |
| io_ctrl_o | output | 8 | I/O control register contents |

## Verification
If an idle counter or the synchroniser history is wrong, the forced pulse arrives early, arrives late or never arrives. A reference that tracks idle time per input shows this within one cycle of the expected pulse edge. If the re-arm flag is stuck, a host cycle gets a second pulse or the next stalled cycle gets none, and this shows at the first clock that `cs_i` is held under loss. A corrupt enable bit appears on `io_ctrl_o` immediately. It then shows at `rdy_o` during the next stalled host cycle.

// File: rtl/loc_pkg.sv
package loc_pkg;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned NUM_LINES   = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 8'h01;
  localparam logic [DATA_W-1:0] CTRL_RESET = 8'hA0;
  localparam int unsigned EN_BIT      = 7;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/loc_edge_watch.sv
module loc_edge_watch #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_LIMIT  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic dead_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_LIMIT);

  // chain[SYNC_STAGES] holds the previous synchronised value
  logic [SYNC_STAGES:0] chain_q;
  logic [CNT_W-1:0]     idle_q;
  logic                 toggle;

  assign toggle = chain_q[SYNC_STAGES] ^ chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[SYNC_STAGES-1:0], line_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idle_q <= '0;
    else if (toggle)          idle_q <= '0;
    else if (idle_q != LIMIT) idle_q <= idle_q + 1'b1;
  end

  assign dead_o = (idle_q == LIMIT);

  assert_toggle_revives_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle |=> !dead_o);
  assert_dead_stays_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dead_o && !toggle) |=> dead_o);
endmodule

// File: rtl/loc_ctrl_reg.sv
module loc_ctrl_reg
  import loc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_i,
  input  logic  we_i,
  input  addr_t addr_i,
  input  data_t wdata_i,
  output data_t ctrl_o,
  output logic  en_o
);
  data_t ctrl_q;
  logic  hit;

  assign hit = cs_i && we_i && (addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ctrl_q <= CTRL_RESET;
    else if (hit) ctrl_q <= wdata_i;
  end

  assign ctrl_o = ctrl_q;
  assign en_o   = ctrl_q[EN_BIT];

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && addr_i == CTRL_ADDR) |=> ctrl_o == $past(wdata_i));
  assert_other_addr_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && we_i && addr_i == CTRL_ADDR) |=> $stable(ctrl_o));
endmodule

// File: rtl/loc_ready_force.sv
module loc_ready_force (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic en_i,
  input  logic loss_i,
  output logic force_o
);
  logic force_q, fired_q, fire;

  assign fire = cs_i && en_i && loss_i && !fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      force_q <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      force_q <= fire;
      fired_q <= cs_i && (fired_q || fire);
    end
  end

  assign force_o = force_q;

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_o |=> !force_o);
  assert_needs_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_o |-> $past(en_i));
  assert_needs_loss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_o |-> $past(loss_i && cs_i));
endmodule

// File: rtl/loc_rescue.sv
module loc_rescue
  import loc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_LIMIT  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_clk_i,
  input  logic       rx_clk_i,
  input  logic       cs_i,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       core_rdy_i,
  output logic       rdy_o,
  output logic [7:0] io_ctrl_o
);
  logic [NUM_LINES-1:0] lines, dead;
  logic en, loss, force_rdy;

  assign lines = {rx_clk_i, tx_clk_i};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_watch
    loc_edge_watch #(
      .SYNC_STAGES(SYNC_STAGES),
      .IDLE_LIMIT (IDLE_LIMIT)
    ) i_watch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(lines[g]),
      .dead_o(dead[g])
    );
  end

  assign loss = &dead;

  loc_ctrl_reg i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_i   (cs_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .ctrl_o (io_ctrl_o),
    .en_o   (en)
  );

  loc_ready_force i_force (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_i   (cs_i),
    .en_i   (en),
    .loss_i (loss),
    .force_o(force_rdy)
  );

  assign rdy_o = core_rdy_i | force_rdy;

  assert_core_passes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rdy_i |-> rdy_o);
  assert_rearm_needs_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_rdy && cs_i) |=> !force_rdy);
endmodule

// File: tb/test_loc_rescue.sv
module test_loc_rescue;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic tx_clk = 0, rx_clk = 0, cs = 0, we = 0, core_rdy = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic rdy;
  logic [7:0] ctrl;

  int checks = 0, fails = 0;
  bit done = 0;
  bit tx_run = 1, rx_run = 1;
  int tx_div = 2, rx_div = 3, tx_cnt = 0, rx_cnt = 0;

  loc_rescue i_loc_rescue (
    .clk_i(clk), .rst_ni(rst_n), .tx_clk_i(tx_clk), .rx_clk_i(rx_clk),
    .cs_i(cs), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .core_rdy_i(core_rdy), .rdy_o(rdy), .io_ctrl_o(ctrl)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tx_run && ++tx_cnt >= tx_div) begin tx_clk <= ~tx_clk; tx_cnt = 0; end
    if (rx_run && ++rx_cnt >= rx_div) begin rx_clk <= ~rx_clk; rx_cnt = 0; end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic hist_tx[$], hist_rx[$];
  int idle_tx, idle_rx;
  bit m_force, m_fired;
  logic [7:0] m_ctrl;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist_tx = {1'b0, 1'b0, 1'b0}; hist_rx = {1'b0, 1'b0, 1'b0};
      idle_tx = 0; idle_rx = 0; m_force = 0; m_fired = 0; m_ctrl = 8'hA0;
    end else begin
      bit loss, fire, en;
      en   = m_ctrl[7];
      loss = (idle_tx == 16) && (idle_rx == 16);
      fire = cs && en && loss && !m_fired;
      if (hist_tx[1] != hist_tx[2]) idle_tx = 0; else if (idle_tx < 16) idle_tx++;
      if (hist_rx[1] != hist_rx[2]) idle_rx = 0; else if (idle_rx < 16) idle_rx++;
      hist_tx.push_front(tx_clk); void'(hist_tx.pop_back());
      hist_rx.push_front(rx_clk); void'(hist_rx.pop_back());
      m_fired = cs && (m_fired || fire);
      m_force = fire;
      if (cs && we && addr == 8'h01) m_ctrl = wdata;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R6 rdy_o vs model", rdy, core_rdy | m_force);
      check("R2 io_ctrl_o vs model", ctrl, m_ctrl);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_cs(int n, output int pulses);
    pulses = 0;
    @(negedge clk); cs = 1; we = 0; addr = 8'h10;
    repeat (n) begin @(posedge clk); #2; if (rdy) pulses++; end
    @(negedge clk); cs = 0;
  endtask

  task automatic write_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  initial begin
    int p, early;
    cycles(3);
    check("R1 reset ctrl", ctrl, 8'hA0);
    check("R1 reset rdy", rdy, 0);
    rst_n = 1;
    cycles(30);

    hold_cs(40, p); check("R4 both running", p, 0);

    tx_run = 0; cycles(30);
    hold_cs(40, p); check("R4 tx stopped only", p, 0);

    tx_run = 1; cycles(10);
    @(negedge clk); tx_run = 0; rx_run = 0; cs = 1; addr = 8'h10;
    early = 0; p = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #2;
      if (rdy) begin p++; if (i < 17) early++; end
    end
    @(negedge clk); cs = 0;
    check("R5 no pulse in first 17 cycles", early, 0);
    check("R6 one pulse per cycle", p, 1);
    hold_cs(10, p); check("R6 rearm after cs low", p, 1);
    hold_cs(3, p);  check("R6 short cycle", p, 1);

    @(negedge clk); core_rdy = 1;
    @(posedge clk); #2; check("R8 core ready passes", rdy, 1);
    @(negedge clk); core_rdy = 0;

    write_reg(8'h01, 8'h20);
    cycles(1); check("R2 write lands", ctrl, 8'h20);
    write_reg(8'h02, 8'hFF);
    cycles(1); check("R2 other address ignored", ctrl, 8'h20);
    hold_cs(30, p); check("R3 disabled no force", p, 0);

    write_reg(8'h01, 8'hA0);
    cycles(1); check("R2 re-enable", ctrl, 8'hA0);
    hold_cs(5, p); check("R5 still lost", p, 1);

    @(negedge clk); rx_run = 1;
    cycles(8);
    hold_cs(30, p); check("R7 loss cleared by rx", p, 0);
    rx_run = 0; cycles(30);
    @(negedge clk); tx_run = 1;
    cycles(8);
    hold_cs(30, p); check("R7 loss cleared by tx", p, 0);

    cycles(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule